// File: doc/BRIEF.md
# Byte-Lane Dual-Port Word Memory with Per-Port Access Decode

This block is a clocked two-port word memory whose ports work independently: each side has its own address, write data and a set of active-low controls. The controls are chip enable, write select, output enable, upper and lower byte selects, a semaphore select and a write-inhibit input. Every cycle, each port's controls are decoded into a read, a byte-lane write, no access, or a forbidden combination. A forbidden combination is reported on a one-cycle error pulse and causes no memory access.

Read data comes out on a data bus together with one valid bit per byte lane. The valid bits take the place of tri-state drivers. A lane whose valid bit is low reads as zero. The semaphore flags and the address-collision arbiter are separate blocks. They reach this controller only through the semaphore select and the inhibit input. When the inhibit input is low, writes from that port are blocked but its reads still complete. This lets an arbiter stall the losing writer without stalling reads.

The default geometry is 2^ADDR_W words of two LANE_W-bit lanes. ADDR_W=14 gives the full 16K x 16 array. The default build uses a smaller depth.

Top module: `dpram_lane_ctrl`

## Requirements
- R1: The memory holds 2^ADDR_W words of two LANE_W-bit lanes. Lane 1 is data bits [2*LANE_W-1:LANE_W] and lane 0 is bits [LANE_W-1:0]. Both ports can access any address, including the highest, in the same cycle. A word written through one port reads back through either port.
- R2: When chip enable (ce_n) is high, the port makes no access. Its dout_vld is 00 in the following cycle and memory is not written.
- R3: When both byte selects (ub_n, lb_n) are high, no lane is read or written and dout_vld is 00.
- R4: A write occurs when ce_n=0, we_n=0 and sem_n=1. Lane 1 is written only when ub_n=0, and lane 0 only when lb_n=0. The value of oe_n has no effect on a write.
- R5: A read occurs when ce_n=0, we_n=1, oe_n=0 and sem_n=1. dout_vld[1] is set when ub_n=0 and dout_vld[0] when lb_n=0. The data bits of any lane whose valid bit is low read as zero.
- R6: When oe_n is high, dout_vld is 00 regardless of the other inputs.
- R7: The combination sem_n=0, ce_n=0 with ub_n=0 or lb_n=0 is forbidden. It raises err for exactly the following cycle, performs no read (dout_vld 00) and performs no write. sem_n=0 with ce_n=1 is not an error.
- R8: While inh_n is low, writes from that port are ignored, but reads from that port complete normally.
- R9: All inputs are sampled on the rising clock edge. dout, dout_vld and err change only at the edge that follows the accepting edge, which gives a latency of one cycle.
- R10: If both ports write the same lane of the same word in one cycle and neither is inhibited, the left port's data is stored. Lanes written by only one port take that port's data.
- R11: A read on one port of a word that the other port writes in the same cycle returns the word's previous contents.
- R12: A synchronous reset (rst high) forces dout_vld to 00 and err to 0 on both ports. Memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write select: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper lane select, active low |
| l_lb_n | input | 1 | Left lower lane select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_inh_n | input | 1 | Left write inhibit, active low |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | 2*LANE_W | Left write data |
| l_dout | output | 2*LANE_W | Left read data, zero in invalid lanes |
| l_dout_vld | output | 2 | Left per-lane output valid (bit 1 upper) |
| l_err | output | 1 | Left forbidden-combination pulse |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write select: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper lane select, active low |
| r_lb_n | input | 1 | Right lower lane select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_inh_n | input | 1 | Right write inhibit, active low |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | 2*LANE_W | Right write data |
| r_dout | output | 2*LANE_W | Right read data, zero in invalid lanes |
| r_dout_vld | output | 2 | Right per-lane output valid (bit 1 upper) |
| r_err | output | 1 | Right forbidden-combination pulse |

## Verification
The bench builds the block with ADDR_W=6 and LANE_W=8. The 64-word depth brings the highest address (63) within reach next to address 0, so both ends of the array are tested. The 8-bit lanes let single-lane writes leave visibly different upper and lower bytes. The small array also lets the bench re-read, a cycle later, every word touched by a blocked write (deselected, inhibited or forbidden) and confirm it is unchanged. The same words serve the same-cycle collisions on one word: full and partial-lane write/write, and write against read.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Active-low control bundle of one port, most significant field first.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic sem_n;
        logic inh_n;
    } port_ctl_t;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2,
        OP_ILLEGAL = 2'd3
    } port_op_e;

endpackage

// File: rtl/dpram_port_decode.sv
module dpram_port_decode
    import dpram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  port_ctl_t          ctl,
    output port_op_e           op,
    output logic [LANES-1:0]   rd_lane,
    output logic [LANES-1:0]   wr_lane,
    output logic               illegal
);

    logic [LANES-1:0] sel;
    logic             mem_cycle;
    logic             any_lane;

    // lane 1 is the upper byte, lane 0 the lower byte
    assign sel       = {~ctl.ub_n, ~ctl.lb_n};
    assign any_lane  = |sel;
    assign mem_cycle = ~ctl.ce_n & ctl.sem_n;

    always_comb begin
        op = OP_NONE;
        if (!ctl.ce_n && !ctl.sem_n && any_lane) begin
            op = OP_ILLEGAL;
        end else if (mem_cycle && any_lane) begin
            op = ctl.we_n ? OP_READ : OP_WRITE;
        end
    end

    assign illegal = (op == OP_ILLEGAL);

    always_comb begin
        rd_lane = '0;
        wr_lane = '0;
        if (op == OP_READ && !ctl.oe_n) begin
            rd_lane = sel;
        end
        if (op == OP_WRITE && ctl.inh_n) begin
            wr_lane = sel;
        end
    end

endmodule

// File: rtl/dpram_lane_bank.sv
module dpram_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [LANE_W-1:0] l_wdata,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [LANE_W-1:0] r_wdata,
    output logic [LANE_W-1:0] l_rdata,
    output logic [LANE_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] l_rdata_q;
    logic [LANE_W-1:0] r_rdata_q;

    // Right write first, left write last: left wins a same-word collision.
    // Reads see the contents from before this edge's writes.
    always_ff @(posedge clk) begin
        if (r_wr) begin
            mem_q[r_addr] <= r_wdata;
        end
        if (l_wr) begin
            mem_q[l_addr] <= l_wdata;
        end
        if (l_rd) begin
            l_rdata_q <= mem_q[l_addr];
        end
        if (r_rd) begin
            r_rdata_q <= mem_q[r_addr];
        end
    end

    assign l_rdata = l_rdata_q;
    assign r_rdata = r_rdata_q;

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        rd_lane,
    input  logic                    illegal,
    input  logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_vld,
    output logic                    err
);

    typedef struct packed {
        logic [LANES-1:0] vld;
        logic             err;
    } out_st_t;

    out_st_t st_d;
    out_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_lane;
        st_d.err = illegal;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = st_q.vld[g] ? rdata[g*LANE_W +: LANE_W] : '0;
    end

    assign dout_vld = st_q.vld;
    assign err      = st_q.err;

    // R7: a forbidden-combination pulse never comes with read data
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
        err |-> (dout_vld == '0));

endmodule

// File: rtl/dpram_lane_ctrl.sv
module dpram_lane_ctrl
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  l_ce_n,
    input  logic                  l_we_n,
    input  logic                  l_oe_n,
    input  logic                  l_ub_n,
    input  logic                  l_lb_n,
    input  logic                  l_sem_n,
    input  logic                  l_inh_n,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [2*LANE_W-1:0]   l_din,
    output logic [2*LANE_W-1:0]   l_dout,
    output logic [1:0]            l_dout_vld,
    output logic                  l_err,
    input  logic                  r_ce_n,
    input  logic                  r_we_n,
    input  logic                  r_oe_n,
    input  logic                  r_ub_n,
    input  logic                  r_lb_n,
    input  logic                  r_sem_n,
    input  logic                  r_inh_n,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [2*LANE_W-1:0]   r_din,
    output logic [2*LANE_W-1:0]   r_dout,
    output logic [1:0]            r_dout_vld,
    output logic                  r_err
);

    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;

    port_ctl_t        l_ctl, r_ctl;
    port_op_e         l_op, r_op;
    logic [LANES-1:0] l_rd, l_wr, r_rd, r_wr;
    logic             l_ill, r_ill;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    assign l_ctl = '{ce_n: l_ce_n, we_n: l_we_n, oe_n: l_oe_n, ub_n: l_ub_n,
                     lb_n: l_lb_n, sem_n: l_sem_n, inh_n: l_inh_n};
    assign r_ctl = '{ce_n: r_ce_n, we_n: r_we_n, oe_n: r_oe_n, ub_n: r_ub_n,
                     lb_n: r_lb_n, sem_n: r_sem_n, inh_n: r_inh_n};

    dpram_port_decode #(.LANES(LANES)) u_dec_l (
        .ctl(l_ctl), .op(l_op), .rd_lane(l_rd), .wr_lane(l_wr), .illegal(l_ill)
    );

    dpram_port_decode #(.LANES(LANES)) u_dec_r (
        .ctl(r_ctl), .op(r_op), .rd_lane(r_rd), .wr_lane(r_wr), .illegal(r_ill)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        dpram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk     (clk),
            .l_wr    (l_wr[g]),
            .l_rd    (l_rd[g]),
            .l_addr  (l_addr),
            .l_wdata (l_din[g*LANE_W +: LANE_W]),
            .r_wr    (r_wr[g]),
            .r_rd    (r_rd[g]),
            .r_addr  (r_addr),
            .r_wdata (r_din[g*LANE_W +: LANE_W]),
            .l_rdata (l_rdata[g*LANE_W +: LANE_W]),
            .r_rdata (r_rdata[g*LANE_W +: LANE_W])
        );
    end

    dpram_port_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out_l (
        .clk(clk), .rst(rst), .rd_lane(l_rd), .illegal(l_ill), .rdata(l_rdata),
        .dout(l_dout), .dout_vld(l_dout_vld), .err(l_err)
    );

    dpram_port_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out_r (
        .clk(clk), .rst(rst), .rd_lane(r_rd), .illegal(r_ill), .rdata(r_rdata),
        .dout(r_dout), .dout_vld(r_dout_vld), .err(r_err)
    );

    // R2: a deselected port shows no valid lane in the next cycle
    a_r2_desel_quiet_l: assert property (@(posedge clk) disable iff (rst)
        $past(l_ce_n) |-> (l_dout_vld == '0));
    a_r2_desel_quiet_r: assert property (@(posedge clk) disable iff (rst)
        $past(r_ce_n) |-> (r_dout_vld == '0));

    // R3: both lane selects high gives no valid lane
    a_r3_no_lane_quiet_l: assert property (@(posedge clk) disable iff (rst)
        $past(l_ub_n && l_lb_n) |-> (l_dout_vld == '0));
    a_r3_no_lane_quiet_r: assert property (@(posedge clk) disable iff (rst)
        $past(r_ub_n && r_lb_n) |-> (r_dout_vld == '0));

    // R6: output enable high blanks both lanes
    a_r6_oe_blank_l: assert property (@(posedge clk) disable iff (rst)
        $past(l_oe_n) |-> (l_dout_vld == '0));
    a_r6_oe_blank_r: assert property (@(posedge clk) disable iff (rst)
        $past(r_oe_n) |-> (r_dout_vld == '0));

    // R8: an inhibited port never reaches the lane banks with a write
    a_r8_inhibit_l: assert property (@(posedge clk) disable iff (rst)
        !l_inh_n |-> (l_wr == '0));
    a_r8_inhibit_r: assert property (@(posedge clk) disable iff (rst)
        !r_inh_n |-> (r_wr == '0));

    // R7: a forbidden combination never reaches the banks at all
    a_r7_no_access_l: assert property (@(posedge clk) disable iff (rst)
        (l_op == OP_ILLEGAL) |-> (l_wr == '0 && l_rd == '0));
    a_r7_no_access_r: assert property (@(posedge clk) disable iff (rst)
        (r_op == OP_ILLEGAL) |-> (r_wr == '0 && r_rd == '0));

endmodule

// File: tb/dpram_lane_ctrl_tb.sv
module dpram_lane_ctrl_tb_top;
    import dpram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int LANE_W     = 8;
    localparam int DW         = 2 * LANE_W;

    // control encodings {ce_n, we_n, oe_n, ub_n, lb_n, sem_n, inh_n}
    localparam port_ctl_t IDLE     = 7'b1111111;
    localparam port_ctl_t WR_BOTH  = 7'b0010011;
    localparam port_ctl_t WR_HI    = 7'b0010111;
    localparam port_ctl_t WR_LO    = 7'b0011011;
    localparam port_ctl_t WR_OE0   = 7'b0000011;
    localparam port_ctl_t WR_NONE  = 7'b0011111;
    localparam port_ctl_t WR_INH   = 7'b0010010;
    localparam port_ctl_t WR_DESEL = 7'b1000011;
    localparam port_ctl_t RD_BOTH  = 7'b0100011;
    localparam port_ctl_t RD_HI    = 7'b0100111;
    localparam port_ctl_t RD_LO    = 7'b0101011;
    localparam port_ctl_t RD_OEH   = 7'b0110011;
    localparam port_ctl_t RD_NONE  = 7'b0101111;
    localparam port_ctl_t RD_INH   = 7'b0100010;
    localparam port_ctl_t ILL_WR   = 7'b0010001;
    localparam port_ctl_t ILL_RD   = 7'b0101001;
    localparam port_ctl_t SEM_ONLY = 7'b1100001;

    typedef struct packed {
        logic [3:0]        req;
        port_ctl_t         lc;
        logic [ADDR_W-1:0] la;
        logic [DW-1:0]     ld;
        port_ctl_t         rc;
        logic [ADDR_W-1:0] ra;
        logic [DW-1:0]     rd;
        logic [1:0]        elv;
        logic [DW-1:0]     eld;
        logic              ele;
        logic [1:0]        erv;
        logic [DW-1:0]     erd;
        logic              ere;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        // R1: both ends of the array written in one cycle
        '{4'd1,  WR_BOTH, 6'd0,  16'h1234, WR_BOTH, 6'd63, 16'hABCD, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R1: cross read-back
        '{4'd1,  RD_BOTH, 6'd63, 16'h0000, RD_BOTH, 6'd0,  16'h0000, 2'b11, 16'hABCD, 1'b0, 2'b11, 16'h1234, 1'b0},
        // R4: single-lane writes
        '{4'd4,  WR_HI,   6'd0,  16'h55AA, WR_LO,   6'd63, 16'h00EE, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R4 / R5: lane merge seen, upper-only read
        '{4'd5,  RD_BOTH, 6'd0,  16'h0000, RD_HI,   6'd63, 16'h0000, 2'b11, 16'h5534, 1'b0, 2'b10, 16'hAB00, 1'b0},
        // R5 lower-only read / R6 oe high
        '{4'd6,  RD_LO,   6'd63, 16'h0000, RD_OEH,  6'd0,  16'h0000, 2'b01, 16'h00EE, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R4: write with oe low still writes
        '{4'd4,  WR_OE0,  6'd1,  16'h0F0F, WR_BOTH, 6'd2,  16'h3C3C, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R3: no lane selected on write and read
        '{4'd3,  WR_NONE, 6'd0,  16'hFFFF, RD_NONE, 6'd0,  16'h0000, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R4: oe-low write landed
        '{4'd4,  RD_BOTH, 6'd1,  16'h0000, RD_BOTH, 6'd2,  16'h0000, 2'b11, 16'h0F0F, 1'b0, 2'b11, 16'h3C3C, 1'b0},
        // R3 word 0 untouched / R2 deselected write
        '{4'd2,  RD_BOTH, 6'd0,  16'h0000, WR_DESEL,6'd1,  16'h9999, 2'b11, 16'h5534, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R7: forbidden combinations on both ports
        '{4'd7,  ILL_WR,  6'd2,  16'h7777, ILL_RD,  6'd0,  16'h0000, 2'b00, 16'h0000, 1'b1, 2'b00, 16'h0000, 1'b1},
        // R8: left write inhibited, right read under inhibit completes
        '{4'd8,  WR_INH,  6'd1,  16'h2222, RD_INH,  6'd1,  16'h0000, 2'b00, 16'h0000, 1'b0, 2'b11, 16'h0F0F, 1'b0},
        // R2 / R7 / R8: blocked writes left words 1 and 2 unchanged
        '{4'd8,  RD_BOTH, 6'd1,  16'h0000, RD_BOTH, 6'd2,  16'h0000, 2'b11, 16'h0F0F, 1'b0, 2'b11, 16'h3C3C, 1'b0},
        // R10: full write/write collision
        '{4'd10, WR_BOTH, 6'd5,  16'h1111, WR_BOTH, 6'd5,  16'h2222, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        '{4'd10, RD_BOTH, 6'd5,  16'h0000, RD_BOTH, 6'd5,  16'h0000, 2'b11, 16'h1111, 1'b0, 2'b11, 16'h1111, 1'b0},
        // R10: partial collision, left upper vs right both
        '{4'd10, WR_HI,   6'd6,  16'hAA00, WR_BOTH, 6'd6,  16'hBBCC, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0},
        '{4'd10, RD_BOTH, 6'd6,  16'h0000, RD_LO,   6'd6,  16'h0000, 2'b11, 16'hAACC, 1'b0, 2'b01, 16'h00CC, 1'b0},
        // R11: read during the other port's write sees old data
        '{4'd11, WR_BOTH, 6'd6,  16'h0101, RD_BOTH, 6'd6,  16'h0000, 2'b00, 16'h0000, 1'b0, 2'b11, 16'hAACC, 1'b0},
        // R11 new data / R7 semaphore access with ce high is no error
        '{4'd7,  RD_BOTH, 6'd6,  16'h0000, SEM_ONLY,6'd6,  16'h0000, 2'b11, 16'h0101, 1'b0, 2'b00, 16'h0000, 1'b0},
        // R8: right write inhibited while left reads under inhibit
        '{4'd8,  RD_INH,  6'd6,  16'h0000, WR_INH,  6'd6,  16'hFFFF, 2'b11, 16'h0101, 1'b0, 2'b00, 16'h0000, 1'b0},
        '{4'd8,  RD_BOTH, 6'd6,  16'h0000, IDLE,    6'd0,  16'h0000, 2'b11, 16'h0101, 1'b0, 2'b00, 16'h0000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    port_ctl_t         lc = IDLE, rc = IDLE;
    logic [ADDR_W-1:0] la = '0, ra = '0;
    logic [DW-1:0]     ld = '0, rd = '0;
    logic [DW-1:0]     l_dout, r_dout;
    logic [1:0]        l_vld, r_vld;
    logic              l_err, r_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_lane_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst(rst),
        .l_ce_n(lc.ce_n), .l_we_n(lc.we_n), .l_oe_n(lc.oe_n), .l_ub_n(lc.ub_n),
        .l_lb_n(lc.lb_n), .l_sem_n(lc.sem_n), .l_inh_n(lc.inh_n),
        .l_addr(la), .l_din(ld), .l_dout(l_dout), .l_dout_vld(l_vld), .l_err(l_err),
        .r_ce_n(rc.ce_n), .r_we_n(rc.we_n), .r_oe_n(rc.oe_n), .r_ub_n(rc.ub_n),
        .r_lb_n(rc.lb_n), .r_sem_n(rc.sem_n), .r_inh_n(rc.inh_n),
        .r_addr(ra), .r_din(rd), .r_dout(r_dout), .r_dout_vld(r_vld), .r_err(r_err)
    );

    task automatic check(input string tag, input logic [1:0] av, input logic [DW-1:0] ad,
                         input logic ae, input logic [1:0] ev, input logic [DW-1:0] ed,
                         input logic ee);
        n_chk++;
        if (av !== ev || ad !== ed || ae !== ee) begin
            n_bad++;
            $display("FAIL %s: actual vld=%b dout=%h err=%b expected vld=%b dout=%h err=%b",
                     tag, av, ad, ae, ev, ed, ee);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 reset left",  l_vld, l_dout, l_err, 2'b00, '0, 1'b0);
        check("R12 reset right", r_vld, r_dout, r_err, 2'b00, '0, 1'b0);
        rst = 1'b0;
        step();

        for (int i = 0; i < NVEC; i++) begin
            lc = VECS[i].lc; la = VECS[i].la; ld = VECS[i].ld;
            rc = VECS[i].rc; ra = VECS[i].ra; rd = VECS[i].rd;
            step();
            check($sformatf("R%0d vector %0d left", VECS[i].req, i),
                  l_vld, l_dout, l_err, VECS[i].elv, VECS[i].eld, VECS[i].ele);
            check($sformatf("R%0d vector %0d right", VECS[i].req, i),
                  r_vld, r_dout, r_err, VECS[i].erv, VECS[i].erd, VECS[i].ere);
        end

        // R9: nothing changes before the accepting edge, data after it
        lc = IDLE; rc = IDLE;
        step();
        lc = RD_BOTH; la = 6'd0;
        #1;
        check("R9 before edge", l_vld, l_dout, l_err, 2'b00, '0, 1'b0);
        step();
        check("R9 after edge", l_vld, l_dout, l_err, 2'b11, 16'h5534, 1'b0);

        // R7: error lasts exactly one cycle
        lc = ILL_RD;
        step();
        check("R7 pulse high", l_vld, l_dout, l_err, 2'b00, '0, 1'b1);
        lc = IDLE;
        step();
        check("R7 pulse gone", l_vld, l_dout, l_err, 2'b00, '0, 1'b0);

        // R12: reset blanks a pending read, memory survives it
        lc = RD_BOTH; la = 6'd63;
        rst = 1'b1;
        step();
        check("R12 reset over read", l_vld, l_dout, l_err, 2'b00, '0, 1'b0);
        rst = 1'b0;
        step();
        check("R12 memory kept", l_vld, l_dout, l_err, 2'b11, 16'hABEE, 1'b0);

        finish_run();
    end

endmodule